// File: doc/BRIEF.md
# Flash Write Status Reporter

This block produces the completion signals that a flash device shows to a host while an internal program or erase is running. The command decoder raises a one-cycle launch pulse together with the kind of operation and the word being written. From then on, a single down-counter stands in for the time the cells need. While it runs, the block drives an active-low ready/busy line and replaces two bits of every data read with status bits.

Bit 7 carries a polarity flag: the inverse of the written bit for a program, and 0 for any erase. Bit 6 changes value on each read, so a host can detect activity by comparing two reads in a row. When the counter expires, a short recovery window follows. During that window bit 7 shows its final value, bit 6 holds still, and reads are still marked as not yet valid. After the window, reads pass through the array data unchanged.

A device reset pin releases the busy line as soon as it goes low. If it stays low long enough, it also aborts the operation in progress. All timing is expressed in clock cycles and set by parameters.

Top module: `flash_wstat`

## Requirements
- R1: A `start` pulse that is sampled while no operation is busy and `dev_rst_n` is high begins an operation. The block is busy from the next cycle. `op_kind` selects the operation: 00 word program, 01 sector erase, 10 block erase, 11 chip erase. A `start` sampled while `dev_rst_n` is low is dropped.
- R2: The busy phase lasts exactly PROG_CYC, SECT_CYC, BLK_CYC or CHIP_CYC cycles, according to `op_kind`.
- R3: While a program is busy, `rd_data[7]` is the complement of bit 7 of the `wdata` word captured at launch.
- R4: While any erase is busy, `rd_data[7]` is 0.
- R5: While busy, `rd_data[6]` shows a toggle flag. The flag is cleared to 0 at launch and inverts after each read cycle (`rd_stb` high with `ce_n` low). The first read therefore sees 0, the next sees 1, and so on.
- R6: The busy phase is followed by RECOV_CYC recovery cycles. During busy and recovery, `rd_ok` is 0. During recovery, `rd_data[7]` is the true value (the captured bit 7 for a program, 1 for an erase) and `rd_data[6]` no longer changes on reads.
- R7: Outside busy and recovery, `rd_ok` is 1 and `rd_data` equals `arr_data`. The bits other than 7 and 6 always pass through from `arr_data`.
- R8: `rb_pull` (1 = the ready/busy line is driven low) is 1 only while busy with `ce_n` low and `dev_rst_n` high. Otherwise the line is released.
- R9: A `start` pulse that arrives while an operation is busy is ignored. The running operation keeps its kind, its bit 7 and its end cycle.
- R10: When `dev_rst_n` is sampled low on RST_MIN_CYC consecutive edges, the operation is aborted and the recovery phase is skipped, so reads pass through at once. A shorter low pulse leaves the operation running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| start | input | 1 | One-cycle launch of an operation |
| op_kind | input | 2 | Operation kind sampled with `start` |
| wdata | input | DW | Word being programmed, sampled with `start` |
| ce_n | input | 1 | Chip enable, active low |
| rd_stb | input | 1 | Read access in this cycle |
| arr_data | input | DW | Array word at the read address |
| dev_rst_n | input | 1 | Device reset pin, active low |
| rd_data | output | DW | Read word, with status bits overlaid |
| rd_ok | output | 1 | Read data is valid array content |
| rb_pull | output | 1 | Drive the ready/busy line low |

## Verification
Two events can land in the same cycle: the last busy cycle and a host read. That read must still return the toggle value and flip the flag. The read one cycle later must return the frozen flag and the true bit 7. The bench provokes this by reading on every cycle of a program and comparing the read at the final busy cycle with the first two recovery reads.

A second collision is a launch pulse that arrives in the middle of a busy phase. It is judged by the original end cycle and bit 7 staying in effect.

// File: rtl/flash_wstat.sv
module flash_wstat #(
  parameter int DW          = 16,
  parameter int PROG_CYC    = 14,
  parameter int SECT_CYC    = 36,
  parameter int BLK_CYC     = 40,
  parameter int CHIP_CYC    = 60,
  parameter int RECOV_CYC   = 5,
  parameter int RST_MIN_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op_kind,
  input  logic [DW-1:0] wdata,
  input  logic          ce_n,
  input  logic          rd_stb,
  input  logic [DW-1:0] arr_data,
  input  logic          dev_rst_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_ok,
  output logic          rb_pull
);
  localparam int MAXE = (SECT_CYC > BLK_CYC) ? SECT_CYC : BLK_CYC;
  localparam int MAXA = (MAXE > CHIP_CYC) ? MAXE : CHIP_CYC;
  localparam int MAXC = (MAXA > PROG_CYC) ? MAXA : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int RW   = $clog2(RECOV_CYC + 1);
  localparam int SW   = $clog2(RST_MIN_CYC + 1);

  logic          busy, rcv, is_prog, d7, tog;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rcnt;
  logic [SW-1:0] rst_cnt;
  logic          rd, abort, launch, stat7;

  function automatic logic [CW-1:0] dur_m1(input logic [1:0] k);
    case (k)
      2'b00:   return CW'(PROG_CYC - 1);
      2'b01:   return CW'(SECT_CYC - 1);
      2'b10:   return CW'(BLK_CYC - 1);
      default: return CW'(CHIP_CYC - 1);
    endcase
  endfunction

  assign rd     = rd_stb & ~ce_n;
  assign abort  = ~dev_rst_n & (rst_cnt == SW'(RST_MIN_CYC - 1));
  assign launch = start & ~busy & dev_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rst_cnt <= '0;
    else if (dev_rst_n) rst_cnt <= '0;
    else if (rst_cnt != SW'(RST_MIN_CYC)) rst_cnt <= rst_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; rcv <= 1'b0; is_prog <= 1'b0; d7 <= 1'b0; tog <= 1'b0;
      cnt <= '0; rcnt <= '0;
    end else if (abort) begin
      busy <= 1'b0; rcv <= 1'b0; tog <= 1'b0; cnt <= '0; rcnt <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      rcv     <= 1'b0;
      is_prog <= (op_kind == 2'b00);
      d7      <= wdata[7];
      tog     <= 1'b0;
      cnt     <= dur_m1(op_kind);
    end else if (busy) begin
      if (rd) tog <= ~tog;
      if (cnt == '0) begin
        busy <= 1'b0;
        rcv  <= 1'b1;
        rcnt <= RW'(RECOV_CYC - 1);
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (rcv) begin
      if (rcnt == '0) rcv <= 1'b0;
      else            rcnt <= rcnt - 1'b1;
    end
  end

  assign stat7 = busy ? (is_prog & ~d7) : (is_prog ? d7 : 1'b1);

  always_comb begin
    rd_data = arr_data;
    if (busy | rcv) begin
      rd_data[7] = stat7;
      rd_data[6] = tog;
    end
  end

  assign rd_ok   = ~(busy | rcv);
  assign rb_pull = busy & ~ce_n & dev_rst_n;
endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          ce_n,
  input logic          rd_stb,
  input logic          dev_rst_n,
  input logic [DW-1:0] arr_data,
  input logic [DW-1:0] rd_data,
  input logic          rd_ok,
  input logic          rb_pull,
  input logic          busy
);
  logic rd;
  assign rd = rd_stb & ~ce_n;

  // R8
  rb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_pull |-> (!ce_n && dev_rst_n));

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && dev_rst_n) |=> busy);

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy && $past(rd && busy)) |-> (rd_data[6] != $past(rd_data[6])));

  // R5
  toggle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (rd_data[6] == 1'b0));

  // R7
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |-> (rd_data == arr_data));

  // R6
  busy_not_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_ok);
endmodule

bind flash_wstat flash_wstat_chk #(.DW(DW)) u_flash_wstat_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ce_n(ce_n), .rd_stb(rd_stb),
  .dev_rst_n(dev_rst_n), .arr_data(arr_data), .rd_data(rd_data),
  .rd_ok(rd_ok), .rb_pull(rb_pull), .busy(busy)
);

// File: tb/test_flash_wstat.sv
module test_flash_wstat;
  localparam int DW = 16, PC = 14, SC = 36, BC = 40, CC = 60, RC = 5, RM = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, start, ce_n, rd_stb, dev_rst_n;
  logic [1:0]    op_kind;
  logic [DW-1:0] wdata, arr_data, rd_data;
  logic          rd_ok, rb_pull;
  int n_chk = 0, n_err = 0;

  flash_wstat #(.DW(DW), .PROG_CYC(PC), .SECT_CYC(SC), .BLK_CYC(BC),
                .CHIP_CYC(CC), .RECOV_CYC(RC), .RST_MIN_CYC(RM)) i_flash_wstat (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind), .wdata(wdata),
    .ce_n(ce_n), .rd_stb(rd_stb), .arr_data(arr_data), .dev_rst_n(dev_rst_n),
    .rd_data(rd_data), .rd_ok(rd_ok), .rb_pull(rb_pull));

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  function automatic int dur_of(input logic [1:0] k);
    case (k)
      2'b00: return PC;
      2'b01: return SC;
      2'b10: return BC;
      default: return CC;
    endcase
  endfunction

  task automatic launch(input logic [1:0] k, input logic [DW-1:0] wd);
    op_kind = k; wdata = wd; start = 1'b1;
    tick;
    start = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tick; tick;
    chk(rb_pull == 1'b0, "R8 reset released", {15'b0, rb_pull}, 16'h0);
    chk(rd_ok && rd_data == arr_data, "R7 reset pass", rd_data, arr_data);
    rst_n = 1'b1; tick;
  endtask

  task automatic t_op(input logic [1:0] k, input logic [DW-1:0] wd);
    int d;
    logic e7, t7;
    d  = dur_of(k);
    e7 = (k == 2'b00) ? ~wd[7] : 1'b0;
    t7 = (k == 2'b00) ? wd[7] : 1'b1;
    launch(k, wd);
    for (int c = 1; c <= d; c++) begin
      chk(rd_data[7] == e7 && rb_pull && !rd_ok,
          (k == 2'b00) ? "R3 program bit7 busy" : "R4 erase bit7 busy",
          {rd_data[15:8], rd_data[7], rb_pull, rd_ok, 5'b0}, {8'h0, e7, 7'h40});
      chk(rd_data[15:8] == arr_data[15:8] && rd_data[5:0] == arr_data[5:0],
          "R7 other bits pass", rd_data, arr_data);
      tick;
    end
    chk(!rb_pull, "R2 busy length", {15'b0, rb_pull}, 16'h0);
    chk(!rd_ok && rd_data[7] == t7, "R6 recovery bit7", {14'b0, rd_ok, rd_data[7]}, {15'b0, t7});
    for (int c = 2; c <= RC; c++) begin
      tick;
      chk(!rd_ok, "R6 recovery length", {15'b0, rd_ok}, 16'h0);
    end
    tick;
    chk(rd_ok && rd_data == arr_data, "R7 idle pass", rd_data, arr_data);
  endtask

  task automatic t_toggle;
    logic [DW-1:0] r1;
    rd_stb = 1'b1;
    launch(2'b00, 16'h0080);
    for (int c = 1; c <= PC; c++) begin
      chk(rd_data[6] == ((c - 1) % 2), (c == PC) ? "R5 read on final busy cycle" : "R5 toggle",
          {15'b0, rd_data[6]}, 16'((c - 1) % 2));
      tick;
    end
    r1 = rd_data;
    chk(rd_data[6] == (PC % 2) && rd_data[7] == 1'b1, "R6 first recovery read",
        {14'b0, rd_data[7], rd_data[6]}, {14'b0, 1'b1, 1'(PC % 2)});
    tick;
    chk(rd_data[6] == r1[6], "R6 toggle frozen", {15'b0, rd_data[6]}, {15'b0, r1[6]});
    rd_stb = 1'b0;
    repeat (RC) tick;
    // R5: leave the flag at 1 and check it is cleared by the next launch
    launch(2'b01, 16'h0);
    rd_stb = 1'b1; tick; rd_stb = 1'b0;
    chk(rd_data[6] == 1'b1, "R5 flag set", {15'b0, rd_data[6]}, 16'h1);
    repeat (SC + RC) tick;
    launch(2'b00, 16'h0);
    chk(rd_data[6] == 1'b0, "R5 cleared at launch", {15'b0, rd_data[6]}, 16'h0);
    repeat (PC + RC) tick;
  endtask

  task automatic t_ignore;
    launch(2'b00, 16'h0080);
    repeat (3) tick;
    launch(2'b11, 16'h0000);
    for (int c = 5; c <= PC; c++) begin
      chk(rb_pull && rd_data[7] == 1'b0, "R9 start ignored while busy",
          {14'b0, rb_pull, rd_data[7]}, 16'h2);
      tick;
    end
    chk(!rb_pull && rd_data[7] == 1'b1, "R9 original end kept", {14'b0, rb_pull, rd_data[7]}, 16'h1);
    repeat (RC) tick;
    chk(rd_ok, "R9 idle after", {15'b0, rd_ok}, 16'h1);
  endtask

  task automatic t_rb;
    launch(2'b10, 16'h0);
    tick;
    ce_n = 1'b1; #1;
    chk(!rb_pull, "R8 released with ce high", {15'b0, rb_pull}, 16'h0);
    ce_n = 1'b0; #1;
    chk(rb_pull, "R8 driven with ce low", {15'b0, rb_pull}, 16'h1);
    dev_rst_n = 1'b0; #1;
    chk(!rb_pull, "R8 released in reset", {15'b0, rb_pull}, 16'h0);
    tick; dev_rst_n = 1'b1; #1;
    chk(rb_pull && !rd_ok, "R10 short pulse no abort", {14'b0, rb_pull, rd_ok}, 16'h2);
    repeat (BC + RC) tick;
    chk(rd_ok, "R10 short pulse run completes", {15'b0, rd_ok}, 16'h1);
  endtask

  task automatic t_abort;
    launch(2'b11, 16'h0);
    repeat (5) tick;
    dev_rst_n = 1'b0;
    repeat (RM - 1) tick;
    chk(!rd_ok, "R10 not yet aborted", {15'b0, rd_ok}, 16'h0);
    tick;
    chk(rd_ok && rd_data == arr_data, "R10 aborted pass", rd_data, arr_data);
    start = 1'b1; op_kind = 2'b00; tick; start = 1'b0;
    chk(rd_ok, "R1 start dropped in reset", {15'b0, rd_ok}, 16'h1);
    dev_rst_n = 1'b1; tick;
    chk(!rb_pull && rd_ok, "R10 stays idle", {14'b0, rb_pull, rd_ok}, 16'h1);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    start = 0; op_kind = 0; wdata = 0; ce_n = 0; rd_stb = 0; dev_rst_n = 1;
    arr_data = 16'hA53C; rst_n = 0;
    t_reset;
    t_op(2'b00, 16'h1280);
    t_op(2'b00, 16'h0001);
    t_op(2'b01, 16'h0000);
    t_op(2'b10, 16'h0000);
    arr_data = 16'h5AC3;
    t_op(2'b11, 16'h0000);
    t_toggle;
    t_ignore;
    t_rb;
    t_abort;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule